// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

The filter sits behind a receive MAC and watches each incoming frame one byte per beat. It gathers the 48-bit destination address from the first six bytes and, when the frame's last byte arrives, issues one verdict: keep or drop. A frame is kept when it arrived intact (CRC-good flag high on the last beat), is long enough, and passes at least one enabled rule: promiscuous, station-address match, all-group-addresses, or a 64-entry hash of group addresses. The hash index is the six most significant bits of a reflected CRC-32 computed over the six address bytes. It selects one bit of a programmable 64-bit table.

Bytes of a running frame flow straight to the output as they arrive. The verdict rides on the frame's final output byte, so a downstream writer can discard or commit what it has buffered. With trailer removal selected, a four-byte holding line delays the stream so that the four CRC bytes never leave the block. Receive enable, and every other rule bit, takes effect only at a frame start. A frame that is under way when the enable drops runs to its end. A frame that began while the filter was stopped produces no output at all.

Both streams use valid/ready. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single output register is empty or is being emptied in the same cycle. An output beat is held unchanged until `out_ready` accepts it. The configuration pins are plain levels.

Top module: `rx_frame_filter`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof`, `out_eof` and `out_accept` stay unchanged into the next cycle.
- R2: `cfg_rx_en` is sampled on the start beat of each frame. A frame that starts with it high is emitted in full, even if it falls mid-frame. A frame that starts with it low emits no output beat, even if it rises mid-frame.
- R3: `cfg_strip`, `cfg_all`, `cfg_uni`, `cfg_mall` and `cfg_hash` are sampled on a frame's start beat. A change during a frame only affects later frames.
- R4: With `cfg_all` set, a frame is accepted whatever its destination address.
- R5: With `cfg_uni` set, a frame whose six destination bytes equal `cfg_station` is accepted. `cfg_station[47:40]` is the first byte on the wire.
- R6: With `cfg_mall` set, any frame whose first destination byte has bit 0 set (a group address) is accepted. The broadcast address FF:FF:FF:FF:FF:FF is included.
- R7: With `cfg_hash` set, a group-address frame is accepted when `cfg_hash_tbl[idx]` is 1. `idx` is bits [31:26] of a CRC-32 register that starts at all ones, uses reflected polynomial 0xEDB88320, and shifts each destination byte in LSB first, with no final complement.
- R8: A frame that matches no enabled rule is emitted with `out_accept` low on its last beat.
- R9: A frame whose `in_crc_ok` is low on its end beat is dropped regardless of address.
- R10: With trailer removal on, an N-byte frame emits its first N-4 bytes, and `out_eof` is on byte N-5. With it off, all N bytes are emitted unchanged.
- R11: A frame shorter than 10 bytes is never accepted.
- R12: `out_sof` marks the first emitted byte of a frame and `out_eof` marks the last. `out_accept` carries the verdict on the `out_eof` beat and is 0 on every other beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_en | input | 1 | Receive enable, sampled per frame |
| cfg_strip | input | 1 | Remove the 4 trailing CRC bytes |
| cfg_all | input | 1 | Accept every frame |
| cfg_uni | input | 1 | Accept frames addressed to the station |
| cfg_mall | input | 1 | Accept every group-address frame |
| cfg_hash | input | 1 | Accept group frames that hit the hash table |
| cfg_station | input | 48 | Station address, first wire byte in [47:40] |
| cfg_hash_tbl | input | 64 | Hash table, bit n for index n |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_ok | input | 1 | Frame CRC good, meaningful with in_eof |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First emitted byte of a frame |
| out_eof | output | 1 | Last emitted byte of a frame |
| out_accept | output | 1 | Verdict, valid on the out_eof beat |

## Verification
The bench flips the enable in the middle of frames, in both directions. A filter that sampled it continuously would cut a running frame short or leak the tail of a stopped one. It also changes the trailer and unicast bits mid-frame, which exposes any rule bit read outside the start beat. Trailer removal is checked under output stalls. An off-by-one holding line would leak a CRC byte or lose a payload byte, and would misplace the end marker. A misplaced end marker shows up as a verdict on the wrong byte. Runt frames, bad-CRC frames, broadcast under each rule, and a hash hit alongside a miss show whether the address rules are wrongly ORed or wrongly qualified.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned DA_BYTES = 6;

  typedef struct packed {
    logic strip;
    logic all;
    logic uni;
    logic mall;
    logic hash;
  } rxf_ctl_t;

  // One byte of reflected CRC-32, LSB first, no complement.
  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ 32'hEDB8_8320;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_da_match.sv
module rxf_da_match
  import rxf_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned MIN_LEN   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic [CNT_W-1:0]        idx,
  input  logic [7:0]              data,
  input  logic                    eof,
  input  logic                    crc_ok,
  input  logic                    live,
  input  rxf_ctl_t                ctl,
  input  logic [8*DA_BYTES-1:0]   station,
  input  logic [2**HASH_BITS-1:0] tbl,
  output logic                    accept
);

  localparam logic [CNT_W-1:0] LAST_MIN = CNT_W'(MIN_LEN - 1);
  localparam logic [CNT_W-1:0] DA_END   = CNT_W'(DA_BYTES);

  logic [8*DA_BYTES-1:0] da_q;
  logic [31:0]           crc_q;
  logic [HASH_BITS-1:0]  hidx;
  logic                  group, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_q  <= '0;
      crc_q <= '1;
    end else if (beat && idx < DA_END) begin
      da_q  <= {da_q[8*DA_BYTES-9:0], data};
      crc_q <= crc32_step((idx == '0) ? 32'hFFFF_FFFF : crc_q, data);
    end
  end

  assign hidx  = crc_q[31 -: HASH_BITS];
  assign group = da_q[8*DA_BYTES-8];
  assign hit   = ctl.all
               | (ctl.uni && da_q == station)
               | (group && (ctl.mall || (ctl.hash && tbl[hidx])));

  assign accept = beat && eof && live && crc_ok && (idx >= LAST_MIN) && hit;

  AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    beat && eof && (idx < LAST_MIN) |-> !accept); // R11
  AST_DA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    beat && (idx >= DA_END) |=> $stable(da_q) && $stable(crc_q)); // R7

endmodule

// File: rtl/rxf_tail_line.sv
module rxf_tail_line #(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       restart,
  input  logic [7:0] d,
  output logic       full,
  output logic [7:0] tail
);

  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL_CNT = FW'(DEPTH);

  logic [7:0]    sr [DEPTH];
  logic [FW-1:0] fill_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)    sr[i] <= '0;
      else if (push) sr[i] <= (i == 0) ? d : sr[(i == 0) ? 0 : i - 1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill_q <= '0;
    else if (push) begin
      if (restart)              fill_q <= FW'(1);
      else if (fill_q != FULL_CNT) fill_q <= fill_q + FW'(1);
    end
  end

  assign full = (fill_q == FULL_CNT);
  assign tail = sr[DEPTH-1];

  AST_LINE_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push && !restart && full |=> full); // R10
  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    push && restart |=> fill_q == FW'(1)); // R10

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int unsigned HASH_BITS = 6,
  parameter int unsigned CRC_BYTES = 4,
  parameter int unsigned MIN_LEN   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_rx_en,
  input  logic                    cfg_strip,
  input  logic                    cfg_all,
  input  logic                    cfg_uni,
  input  logic                    cfg_mall,
  input  logic                    cfg_hash,
  input  logic [47:0]             cfg_station,
  input  logic [2**HASH_BITS-1:0] cfg_hash_tbl,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic                    in_crc_ok,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data,
  output logic                    out_sof,
  output logic                    out_eof,
  output logic                    out_accept
);

  localparam int unsigned CNT_W = $clog2(MIN_LEN) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fire, emit, m_accept, tl_full, pend_q;
  logic             live_q, cur_live;
  logic [CNT_W-1:0] cnt_q, idx;
  logic [7:0]       tl_tail;
  rxf_ctl_t         ctl_in, ctl_q, cur_ctl;

  assign ctl_in   = '{strip: cfg_strip, all: cfg_all, uni: cfg_uni,
                      mall: cfg_mall, hash: cfg_hash};
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign idx      = in_sof ? '0 : cnt_q;
  assign cur_live = in_sof ? cfg_rx_en : live_q;
  assign cur_ctl  = in_sof ? ctl_in : ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
      ctl_q  <= '0;
      pend_q <= 1'b0;
    end else if (fire) begin
      cnt_q <= (idx == CNT_MAX) ? idx : idx + CNT_W'(1);
      if (in_sof) begin
        live_q <= cfg_rx_en;
        ctl_q  <= ctl_in;
      end
      if (emit)        pend_q <= 1'b0;
      else if (in_sof) pend_q <= 1'b1;
    end
  end

  rxf_da_match #(.HASH_BITS(HASH_BITS), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_match (
    .clk(clk), .rst_n(rst_n), .beat(fire), .idx(idx), .data(in_data),
    .eof(in_eof), .crc_ok(in_crc_ok), .live(cur_live), .ctl(cur_ctl),
    .station(cfg_station), .tbl(cfg_hash_tbl), .accept(m_accept)
  );

  rxf_tail_line #(.DEPTH(CRC_BYTES)) u_tail (
    .clk(clk), .rst_n(rst_n),
    .push(fire && cur_live && cur_ctl.strip),
    .restart(in_sof), .d(in_data), .full(tl_full), .tail(tl_tail)
  );

  assign emit = fire && cur_live && (!cur_ctl.strip || (!in_sof && tl_full));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_accept <= 1'b0;
    end else if (emit) begin
      out_valid  <= 1'b1;
      out_data   <= cur_ctl.strip ? tl_tail : in_data;
      out_sof    <= in_sof || pend_q;
      out_eof    <= in_eof;
      out_accept <= m_accept;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
                                && $stable(out_eof) && $stable(out_accept)); // R1
  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cur_live |=> !out_valid); // R2
  AST_VERDICT_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eof |-> !out_accept); // R12

endmodule

// File: tb/test_rx_frame_filter.sv
module test_rx_frame_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rx_en = 0, cfg_strip = 0, cfg_all = 0, cfg_uni = 0, cfg_mall = 0, cfg_hash = 0;
  logic [47:0] cfg_station = 48'h02_11_22_33_44_55;
  logic [63:0] cfg_hash_tbl = '0;
  logic        in_valid = 0, in_sof = 0, in_eof = 0, in_crc_ok = 0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_sof, out_eof, out_accept;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int vectors = 0, miscompares = 0;
  bit stall_en = 0;
  int ncyc = 0;
  logic [7:0] fb [64];
  logic [7:0] q_data [$];
  bit q_sof [$], q_eof [$], q_acc [$];

  always #2 clk = ~clk;

  rx_frame_filter i_rx_frame_filter (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_strip(cfg_strip),
    .cfg_all(cfg_all), .cfg_uni(cfg_uni), .cfg_mall(cfg_mall), .cfg_hash(cfg_hash),
    .cfg_station(cfg_station), .cfg_hash_tbl(cfg_hash_tbl),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_crc_ok(in_crc_ok), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_accept(out_accept)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output monitor: drives out_ready, records handshakes, checks hold (R1)
  logic [7:0] prev_data;
  bit prev_stall = 0;
  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (prev_stall) chk(out_valid && out_data == prev_data, "R1 hold", int'(out_data), int'(prev_data));
      out_ready = !(stall_en && (ncyc % 3 == 0));
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        q_data.push_back(out_data); q_sof.push_back(out_sof);
        q_eof.push_back(out_eof);   q_acc.push_back(out_accept);
      end
    end
  end

  function automatic logic [5:0] hidx_of(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d = da[47-8*k -: 8];
      for (int b = 0; b < 8; b++) c = (c[0] ^ d[b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic bit model_accept(input logic [47:0] da, input int len, input bit ok);
    bit grp = da[40];
    if (!ok || len < 10) return 0;
    return cfg_all || (cfg_uni && da == cfg_station) ||
           (grp && (cfg_mall || (cfg_hash && cfg_hash_tbl[hidx_of(da)])));
  endfunction

  task automatic build(input logic [47:0] da, input int len);
    for (int i = 0; i < 64; i++) fb[i] = 8'((i * 7 + len) & 255);
    for (int i = 0; i < 6; i++) fb[i] = da[47-8*i -: 8];
  endtask

  // flip: 0 none, 1 enable, 2 strip, 3 unicast; toggled while driving byte flip_at
  task automatic send(input int len, input bit ok, input int flip_at, input int flip);
    q_data.delete(); q_sof.delete(); q_eof.delete(); q_acc.delete();
    for (int i = 0; i < len; i++) begin
      bit took = 0;
      while (!took) begin
        @(negedge clk);
        if (i == flip_at) begin
          if (flip == 1) cfg_rx_en = !cfg_rx_en;
          if (flip == 2) cfg_strip = !cfg_strip;
          if (flip == 3) cfg_uni   = !cfg_uni;
        end
        in_valid = 1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == len - 1);
        in_crc_ok = ok;
        #1 took = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_frame(input int len, input bit live, input bit acc, input bit strip, input string req);
    int n = live ? (strip ? len - 4 : len) : 0;
    int bad = 0, fbad = 0;
    chk(q_data.size() == n, {req, " length"}, q_data.size(), n);
    if (q_data.size() == n) begin
      for (int i = 0; i < n; i++) begin
        if (q_data[i] != fb[i]) bad++;
        if (q_sof[i] != (i == 0) || q_eof[i] != (i == n - 1)) fbad++;
        if (i < n - 1 && q_acc[i]) fbad++;
      end
      chk(bad == 0, {req, " bytes"}, bad, 0);
      chk(fbad == 0, {req, " R12 markers"}, fbad, 0);
      if (n > 0) chk(q_acc[n-1] == acc, {req, " verdict"}, int'(q_acc[n-1]), int'(acc));
    end
  endtask

  task automatic frame(input logic [47:0] da, input int len, input bit ok, input string req);
    bit acc = model_accept(da, len, ok);
    build(da, len);
    send(len, ok, -1, 0);
    expect_frame(len, 1, acc, cfg_strip, req);
  endtask

  task automatic set_rules(input bit a, input bit u, input bit m, input bit h);
    @(negedge clk); cfg_all = a; cfg_uni = u; cfg_mall = m; cfg_hash = h;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 reset in_ready", int'(in_ready), 1);
  endtask

  task automatic t_unicast;
    set_rules(0, 1, 0, 0);
    frame(cfg_station, 20, 1, "R5 station");
    frame(48'h02_11_22_33_44_56, 20, 1, "R8 other unicast");
    frame(48'hFF_FF_FF_FF_FF_FF, 20, 1, "R8 broadcast uni-only");
  endtask

  task automatic t_promisc;
    set_rules(1, 0, 0, 0);
    frame(48'h0A_BC_DE_F0_12_34, 16, 1, "R4 any unicast");
    frame(48'h33_33_00_00_00_01, 16, 1, "R4 any group");
  endtask

  task automatic t_mcast_all;
    set_rules(0, 0, 1, 0);
    frame(48'hFF_FF_FF_FF_FF_FF, 18, 1, "R6 broadcast");
    frame(48'h01_00_5E_01_02_03, 18, 1, "R6 group");
    frame(48'h00_00_5E_01_02_03, 18, 1, "R8 unicast under mall");
  endtask

  task automatic t_hash;
    logic [47:0] hit_da  = 48'h01_00_5E_00_00_01;
    logic [47:0] miss_da = 48'h01_00_5E_00_00_02;
    @(negedge clk);
    cfg_hash_tbl = 64'd1 << hidx_of(hit_da);
    set_rules(0, 0, 0, 1);
    frame(hit_da, 24, 1, "R7 hash hit");
    if (hidx_of(miss_da) == hidx_of(hit_da)) miss_da = 48'h01_00_5E_7F_00_09;
    frame(miss_da, 24, 1, "R7 hash miss");
  endtask

  task automatic t_crc_bad;
    set_rules(1, 1, 1, 0);
    frame(cfg_station, 15, 0, "R9 bad crc");
  endtask

  task automatic t_runt;
    set_rules(0, 1, 0, 0);
    frame(cfg_station, 8, 1, "R11 runt");
    frame(cfg_station, 10, 1, "R11 minimum");
  endtask

  task automatic t_strip;
    set_rules(0, 1, 0, 0);
    @(negedge clk); cfg_strip = 1;
    frame(cfg_station, 16, 1, "R10 strip");
    frame(cfg_station, 10, 1, "R10 strip short");
    @(negedge clk); cfg_strip = 0;
    frame(cfg_station, 16, 1, "R10 pass crc");
  endtask

  task automatic t_stop;
    set_rules(0, 1, 0, 0);
    build(cfg_station, 14);
    send(14, 1, 5, 1);
    expect_frame(14, 1, 1, 0, "R2 finish after disable");
    send(14, 1, -1, 0);
    expect_frame(14, 0, 0, 0, "R2 stopped");
    send(14, 1, 5, 1);
    expect_frame(14, 0, 0, 0, "R2 enable mid-frame");
    send(14, 1, -1, 0);
    expect_frame(14, 1, 1, 0, "R2 running again");
  endtask

  task automatic t_ctl_sample;
    set_rules(0, 1, 0, 0);
    build(cfg_station, 20);
    send(20, 1, 3, 2);
    expect_frame(20, 1, 1, 0, "R3 strip change mid-frame");
    send(20, 1, -1, 0);
    expect_frame(20, 1, 1, 1, "R3 strip next frame");
    send(20, 1, 2, 3);
    expect_frame(20, 1, 1, 1, "R3 uni change mid-frame");
    @(negedge clk); cfg_strip = 0; cfg_uni = 1;
  endtask

  task automatic t_backpressure;
    set_rules(0, 1, 0, 0);
    @(negedge clk); stall_en = 1; cfg_strip = 1;
    frame(cfg_station, 30, 1, "R1 stalled strip");
    @(negedge clk); cfg_strip = 0;
    frame(cfg_station, 25, 1, "R1 stalled pass");
    @(negedge clk); stall_en = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1; cfg_rx_en = 1;
    t_reset;
    t_unicast;
    t_promisc;
    t_mcast_all;
    t_hash;
    t_crc_bad;
    t_runt;
    t_strip;
    t_stop;
    t_ctl_sample;
    t_backpressure;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule